// File: doc/BRIEF.md
# Normally-Opaque Handshake Latch Stage

This block is one stage of a 4-phase bundled-data pipeline, modelled cycle by cycle on a clock. The storage latch is opaque when the stage is idle. It becomes transparent only when a new item arrives at an empty stage. The transparent window lasts a fixed number of cycles. The latch then closes and holds the captured value. This keeps glitches on the incoming data from reaching the output and from rippling down a chain of stages.

The input and output channels each run a full request/acknowledge cycle. Both channels keep their data valid from the rise of the request to the fall of the acknowledge. The stage acknowledges its input as soon as the latch has closed, without waiting for the downstream side. A configurable settle delay separates the closing of the latch from the output request. The stage is marked full after a capture. It is marked empty only when the downstream handshake has fully returned to zero. While the stage is full, no new item can be captured.

Top module: `opaque_hs_stage`

## Requirements
- R1: During and right after reset: `latch_hold` = 1, `in_ack` = 0, `out_req` = 0, `out_data` = 0.
- R2: `latch_hold` goes 0 only at an edge where `in_req` was 1 and `in_ack` was 0 while the stage was empty. Otherwise it stays 1.
- R3: Each transparent window (`latch_hold` = 0) lasts exactly OPEN_CYC consecutive cycles.
- R4: `out_data` changes only at an edge that follows a cycle with `latch_hold` = 0. Activity on `in_data` while the latch is opaque never reaches `out_data`.
- R5: `in_ack` rises one cycle after `latch_hold` returns to 1, and it stays 1 until `in_req` falls.
- R6: `out_req` rises SETTLE_CYC + 2 cycles after `latch_hold` returns to 1.
- R7: `out_data` is stable from the rise of `out_req` until `out_ack` falls, and `out_req` drops the cycle after it sees `out_ack` high.
- R8: While the stage holds an item whose downstream handshake has not returned to zero, `latch_hold` stays 1 and a waiting `in_req` gets no `in_ack`.
- R9: The input handshake can finish (`in_ack` back to 0) while `out_req` is still high and unacknowledged.
- R10: A chain of stages delivers every item in order and with its value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_req | input | 1 | Upstream request |
| in_ack | output | 1 | Upstream acknowledge |
| in_data | input | DATA_W | Upstream data, bundled with in_req |
| out_req | output | 1 | Downstream request |
| out_ack | input | 1 | Downstream acknowledge |
| out_data | output | DATA_W | Latched data to downstream |
| latch_hold | output | 1 | Latch control: 0 transparent, 1 opaque |

## Verification
Suppose the full flag is wrong and reads empty while an item still waits downstream. Then the latch opens under a raised `out_req`, and within one cycle `out_data` changes while the output data must be held. That breaks the output validity check and the in-order scoreboard. A miscounted transparent window or a shortened settle path changes the number of cycles between the latch closing and `in_ack` or `out_req`. The first handshake after reset shows this. A latch that leaks while opaque passes the glitches injected on `in_data` straight to `out_data` within a cycle.

// File: rtl/opq_stage_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the normally-opaque handshake stage.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable subset.
package opq_stage_pkg;

    // Capture phase of the latch controller.
    typedef enum logic [0:0] {
        CAP_SHUT = 1'b0,
        CAP_OPEN = 1'b1
    } cap_state_e;

    // Next value of a Muller C-element: follow inputs when they agree.
    function automatic logic c_next(input logic a, input logic b, input logic q);
        return (a & b) | (q & (a | b));
    endfunction

endpackage

// File: rtl/opq_celem.sv
`timescale 1ns/1ps
// Clocked Muller C-element.
// Output copies the inputs when both agree, otherwise holds.
// Assumes: inputs are synchronous to clk; RST_VAL sets the value after reset.
module opq_celem #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic a,
    input  logic b,
    output logic q
);
    import opq_stage_pkg::*;

    // State update: reset, else C-element rule.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= c_next(a, b, q);
    end
endmodule

// File: rtl/opq_delay_line.sv
`timescale 1ns/1ps
// Delay-chain model: a pulse entering din leaves dout DEPTH cycles later.
// DEPTH = 0 turns the chain into a wire.
// Assumes: din is synchronous to clk.
module opq_delay_line #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    generate
        if (DEPTH == 0) begin : g_wire
            wire unused_clk_rst = clk ^ rst_n;
            assign dout = din;
        end else begin : g_regs
            logic tap [DEPTH];
            for (genvar i = 0; i < DEPTH; i++) begin : g_tap
                // One delay element per tap.
                always_ff @(posedge clk) begin
                    if (!rst_n)      tap[i] <= 1'b0;
                    else if (i == 0) tap[i] <= din;
                    else             tap[i] <= tap[(i == 0) ? 0 : i - 1];
                end
            end
            assign dout = tap[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/opq_capture_ctl.sv
`timescale 1ns/1ps
// Input-side controller.
// Keeps the latch opaque at rest and opens it for OPEN_CYC cycles when a
// request meets an empty stage. It then closes the latch, marks the stage
// full, issues a one-cycle capture pulse, and raises the ack token.
// Assumes: OPEN_CYC >= 1; stage_clr is asserted only while full.
module opq_capture_ctl #(
    parameter int unsigned OPEN_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_req,
    input  logic in_ack,
    input  logic stage_clr,
    output logic lt,
    output logic full,
    output logic ack_tok,
    output logic cap_done
);
    import opq_stage_pkg::*;

    localparam int unsigned CW = (OPEN_CYC > 1) ? $clog2(OPEN_CYC) : 1;

    cap_state_e    state;
    logic [CW-1:0] cnt;
    logic          start;
    logic          close_now;

    assign start     = (state == CAP_SHUT) && in_req && !in_ack && !full && !ack_tok;
    assign close_now = (state == CAP_OPEN) && (cnt == '0);
    assign lt        = (state == CAP_SHUT);

    // Window sequencing: open on start, count down, close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= CAP_SHUT;
            cnt      <= '0;
            cap_done <= 1'b0;
        end else begin
            cap_done <= 1'b0;
            if (start) begin
                state <= CAP_OPEN;
                cnt   <= CW'(OPEN_CYC - 1);
            end else if (close_now) begin
                state    <= CAP_SHUT;
                cap_done <= 1'b1;
            end else if (state == CAP_OPEN) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // Occupancy flag: set by a capture, cleared when downstream is done.
    always_ff @(posedge clk) begin
        if (!rst_n)         full <= 1'b0;
        else if (close_now) full <= 1'b1;
        else if (stage_clr) full <= 1'b0;
    end

    // Ack token: one request worth of permission for the input C-element.
    always_ff @(posedge clk) begin
        if (!rst_n)         ack_tok <= 1'b0;
        else if (close_now) ack_tok <= 1'b1;
        else if (in_ack)    ack_tok <= 1'b0;
    end
endmodule

// File: rtl/opq_out_ctl.sv
`timescale 1ns/1ps
// Output-side controller.
// A launch pulse arms a pending flag. A C-element of the pending flag and
// the inverted downstream ack drives out_req. stage_clr reports the end
// of the output handshake.
// Assumes: launch arrives only while out_ack is low.
module opq_out_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic out_ack,
    output logic out_req,
    output logic stage_clr
);
    logic pend;
    logic sent;
    logic ack_n;

    assign ack_n     = ~out_ack;
    assign stage_clr = sent && !out_req && !out_ack;

    // Pending request: armed by launch, consumed once out_req is up.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend <= 1'b0;
        else if (launch)  pend <= 1'b1;
        else if (out_req) pend <= 1'b0;
    end

    // Handshake-in-flight marker, retired when both wires are back low.
    always_ff @(posedge clk) begin
        if (!rst_n)         sent <= 1'b0;
        else if (out_req)   sent <= 1'b1;
        else if (stage_clr) sent <= 1'b0;
    end

    opq_celem #(.RST_VAL(1'b0)) u_req_c (
        .clk  (clk),
        .rst_n(rst_n),
        .a    (pend),
        .b    (ack_n),
        .q    (out_req)
    );
endmodule

// File: rtl/opq_data_latch.sv
`timescale 1ns/1ps
// Data latch model: follows d on every edge while lt = 0, holds while lt = 1.
// Assumes: d is valid during the transparent window.
module opq_data_latch #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lt,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    // Storage: sample only while transparent.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (!lt) q <= d;
    end
endmodule

// File: rtl/opaque_hs_stage.sv
`timescale 1ns/1ps
// Normally-opaque 4-phase bundled-data pipeline stage.
// Ties together the capture controller, data latch, settle delay chain,
// input-ack C-element and output controller.
// Assumes: both channels keep data valid from request rise to ack fall;
// OPEN_CYC >= 1.
module opaque_hs_stage #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned OPEN_CYC   = 2,
    parameter int unsigned SETTLE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_req,
    output logic              in_ack,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_req,
    input  logic              out_ack,
    output logic [DATA_W-1:0] out_data,
    output logic              latch_hold
);
    logic full;
    logic ack_tok;
    logic cap_done;
    logic launch;
    logic stage_clr;

    opq_capture_ctl #(.OPEN_CYC(OPEN_CYC)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_req   (in_req),
        .in_ack   (in_ack),
        .stage_clr(stage_clr),
        .lt       (latch_hold),
        .full     (full),
        .ack_tok  (ack_tok),
        .cap_done (cap_done)
    );

    opq_data_latch #(.DATA_W(DATA_W)) u_lat (
        .clk  (clk),
        .rst_n(rst_n),
        .lt   (latch_hold),
        .d    (in_data),
        .q    (out_data)
    );

    opq_celem #(.RST_VAL(1'b0)) u_ack_c (
        .clk  (clk),
        .rst_n(rst_n),
        .a    (in_req),
        .b    (ack_tok),
        .q    (in_ack)
    );

    opq_delay_line #(.DEPTH(SETTLE_CYC)) u_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cap_done),
        .dout (launch)
    );

    opq_out_ctl u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .out_ack  (out_ack),
        .out_req  (out_req),
        .stage_clr(stage_clr)
    );

    wire unused_full = full;
endmodule

// File: rtl/opaque_hs_stage_chk.sv
`timescale 1ns/1ps
// Protocol checker for opaque_hs_stage, attached by bind.
// Assumes: synchronous active-low reset shared with the stage.
module opaque_hs_stage_chk #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned OPEN_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_req,
    input logic              in_ack,
    input logic              out_req,
    input logic              out_ack,
    input logic              latch_hold,
    input logic [DATA_W-1:0] out_data
);
    logic [15:0] low_run;

    // Length of the current transparent window.
    always_ff @(posedge clk) begin
        if (!rst_n)          low_run <= '0;
        else if (!latch_hold) low_run <= low_run + 1'b1;
        else                 low_run <= '0;
    end

    AST_OPEN_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(latch_hold) |-> ($past(in_req) && !$past(in_ack))); // R2
    AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch_hold) |-> (low_run == 16'(OPEN_CYC))); // R3
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        latch_hold |=> $stable(out_data)); // R4
    AST_ACK_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch_hold) |=> $rose(in_ack)); // R5
    AST_OUT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req || out_ack) |=> $stable(out_data)); // R7
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req && out_ack) |=> !out_req); // R7
    AST_NO_CAPTURE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        out_req |-> latch_hold); // R8
endmodule

bind opaque_hs_stage opaque_hs_stage_chk #(
    .DATA_W  (DATA_W),
    .OPEN_CYC(OPEN_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_req    (in_req),
    .in_ack    (in_ack),
    .out_req   (out_req),
    .out_ack   (out_ack),
    .latch_hold(latch_hold),
    .out_data  (out_data)
);

// File: tb/sim_opaque_hs_stage.sv
`timescale 1ns/1ps
// Bench: a chain of NST stages, glitchy random source, stalling random sink.
module sim_opaque_hs_stage;
    localparam int DW     = 8;
    localparam int OPEN   = 2;
    localparam int SETTLE = 2;
    localparam int NST    = 3;
    localparam int NRAND  = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          src_req = 1'b0;
    logic [DW-1:0] src_d = '0;
    logic          sink_ack = 1'b0;
    logic          sink_stall = 1'b0;

    logic          req [NST+1];
    logic          ack [NST+1];
    logic [DW-1:0] dat [NST+1];
    logic          lt  [NST];

    assign req[0]   = src_req;
    assign dat[0]   = src_d;
    assign ack[NST] = sink_ack;

    opaque_hs_stage #(.DATA_W(DW), .OPEN_CYC(OPEN), .SETTLE_CYC(SETTLE)) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_req(req[0]), .in_ack(ack[0]), .in_data(dat[0]),
        .out_req(req[1]), .out_ack(ack[1]), .out_data(dat[1]),
        .latch_hold(lt[0])
    );

    for (genvar i = 1; i < NST; i++) begin : g_stg
        opaque_hs_stage #(.DATA_W(DW), .OPEN_CYC(OPEN), .SETTLE_CYC(SETTLE)) u_stg (
            .clk(clk), .rst_n(rst_n),
            .in_req(req[i]), .in_ack(ack[i]), .in_data(dat[i]),
            .out_req(req[i+1]), .out_ack(ack[i+1]), .out_data(dat[i+1]),
            .latch_hold(lt[i])
        );
    end

    int checks = 0;
    int errors = 0;
    int sent = 0;
    int rcvd = 0;
    logic [DW-1:0] exp_q [$];

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int settle_delay();
        return SETTLE + 2;
    endfunction

    // Port monitor at negedge.
    logic          lt_prev [NST];
    logic [DW-1:0] d_prev  [NST];
    int  r4_leaks [NST];
    int  r2_bad = 0;
    int  lt0_falls = 0;
    int  low_run = 0;
    int  since = 0;
    logic ack0_prev = 1'b0;
    logic req1_prev = 1'b0;
    logic inreq_prev = 1'b0;

    initial for (int i = 0; i < NST; i++) begin
        lt_prev[i] = 1'b1; d_prev[i] = '0; r4_leaks[i] = 0;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NST; i++) begin
                if (lt_prev[i] && dat[i+1] !== d_prev[i]) r4_leaks[i]++;
                lt_prev[i] = lt[i];
                d_prev[i]  = dat[i+1];
            end
            if (!lt[0] && lt_prev_0) begin
                lt0_falls++;
                if (!(inreq_prev && !ack0_prev)) r2_bad++;
            end
            if (!lt[0]) low_run++;
            if (lt[0] && !lt_prev_0) begin
                check(low_run == OPEN, "R3 window length", low_run, OPEN);
                low_run = 0;
                since = 0;
            end else begin
                since++;
            end
            if (ack[0] && !ack0_prev)
                check(since == 1, "R5 in_ack after close", since, 1);
            if (req[1] && !req1_prev)
                check(since == settle_delay(), "R6 out_req after close", since, settle_delay());
            lt_prev_0  = lt[0];
            ack0_prev  = ack[0];
            req1_prev  = req[1];
            inreq_prev = req[0];
        end
    end
    logic lt_prev_0 = 1'b1;

    // Source: glitch data while idle, then raise a request.
    task automatic raise_req(input logic [DW-1:0] v, input int glitches);
        for (int k = 0; k < glitches; k++) begin
            @(posedge clk); #1 src_d = DW'($urandom);
        end
        @(posedge clk); #1;
        src_d = v;
        src_req = 1'b1;
        exp_q.push_back(v);
        sent++;
    endtask

    task automatic finish_req();
        do @(negedge clk); while (!ack[0]);
        @(posedge clk); #1 src_req = 1'b0;
        do @(negedge clk); while (ack[0]);
    endtask

    // Sink: random latency, compares against the scoreboard (R10).
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !sink_stall && req[NST] && !sink_ack) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 unexpected item", dat[NST], 0);
                end else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    check(dat[NST] == e, "R10 item value", dat[NST], e);
                end
                rcvd++;
                repeat ($urandom_range(0, 4)) @(posedge clk);
                @(posedge clk); #1 sink_ack = 1'b1;
                do @(negedge clk); while (req[NST]);
                repeat ($urandom_range(0, 3)) @(posedge clk);
                @(posedge clk); #1 sink_ack = 1'b0;
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int lt_snap;
        void'($urandom(32'h5eed_0b1e));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(lt[0] == 1'b1,  "R1 latch_hold in reset", lt[0], 1);
        check(ack[0] == 1'b0, "R1 in_ack in reset", ack[0], 0);
        check(req[1] == 1'b0, "R1 out_req in reset", req[1], 0);
        check(dat[1] == '0,   "R1 out_data in reset", dat[1], 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // Random traffic with glitches before each request.
        for (int n = 0; n < NRAND; n++) begin
            raise_req(DW'($urandom), $urandom_range(0, 5));
            finish_req();
        end
        // Directed corner: back-to-back requests with no gap, no glitches.
        for (int n = 0; n < 4; n++) begin
            raise_req(DW'(8'hA0 + n), 0);
            finish_req();
        end
        while (rcvd != sent) @(negedge clk);

        // Stall: fill the chain with NST items.
        sink_stall = 1'b1;
        raise_req(8'h11, 3); finish_req();
        raise_req(8'h22, 3); finish_req();
        raise_req(8'h33, 3); finish_req();
        repeat (20) @(negedge clk);
        check(req[NST] == 1'b1, "R7 out_req held under stall", req[NST], 1);
        check(dat[NST] == 8'h11, "R7 out_data held under stall", dat[NST], 8'h11);
        check(req[1] && !ack[1] && !ack[0], "R9 input done while output pending",
              {req[1], ack[1], ack[0]}, 3'b100);
        // Fourth item must wait.
        lt_snap = lt0_falls;
        raise_req(8'h44, 0);
        repeat (60) @(negedge clk);
        check(ack[0] == 1'b0, "R8 no ack while full", ack[0], 0);
        check(lt0_falls == lt_snap, "R8 latch stayed opaque while full", lt0_falls - lt_snap, 0);
        check(dat[1] == 8'h33, "R8 held item intact", dat[1], 8'h33);
        sink_stall = 1'b0;
        finish_req();
        while (rcvd != sent) @(negedge clk);
        repeat (10) @(negedge clk);

        check(rcvd == sent, "R10 item count", rcvd, sent);
        check(exp_q.size() == 0, "R10 scoreboard empty", exp_q.size(), 0);
        check(r2_bad == 0, "R2 opening only on request", r2_bad, 0);
        for (int i = 0; i < NST; i++)
            check(r4_leaks[i] == 0, "R4 opaque output stable", r4_leaks[i], 0);
        finish_run();
    end
endmodule